// File: doc/BRIEF.md
# Even-Parity Asynchronous Character Receiver

This block recovers eleven-bit asynchronous characters from a serial line that idles high. Each character is a low start bit, eight data bits sent least significant first, an even-parity bit and a high stop bit. The line is synchronised into the clock domain and sampled sixteen times per bit, and every bit is decided by a two-of-three vote around its centre. The block delivers each octet with a one-cycle strobe, together with a parity-error flag and a stop-bit-error flag.

The receiver also measures how long the line rests high between the stop bit of one character and the start bit of the next. If a whole bit time or more of idle separates them, a gap flag is raised with the strobe of the later character. A downstream frame checker uses this flag to reject frames whose characters were not sent back to back. The bit rate is set by a divider parameter: the number of clock cycles per oversampling tick.

Top module: `parity_char_rx`

## Requirements
- R1: While reset is asserted, and after it is released with the line idle, `valid_o`, `par_err_o`, `stop_err_o` and `gap_o` are 0.
- R2: The first data bit after the start bit lands in `data_o[0]` and the eighth lands in `data_o[7]`. `data_o` carries the octet in the cycle where `valid_o` is 1.
- R3: `par_err_o` is 1 with the strobe exactly when the count of ones across the eight data bits and the parity bit is odd.
- R4: A 0 sampled in the stop position sets `stop_err_o` with that character's strobe. The character is still delivered, and the rest of the low stop bit does not produce an extra character.
- R5: When the line rests at 1 for one whole bit time or more between a stop bit and the next start bit, `gap_o` is 1 in the strobe cycle of the later character.
- R6: A start bit that no longer reads 0 at its centre is discarded with no strobe, and the next valid character is received normally.
- R7: Characters sent with no idle between them have `gap_o` at 0.
- R8: The first character after reset has `gap_o` at 0, whatever idle time preceded it.
- R9: `valid_o` is high for exactly one clock cycle per character. Two strobes are never closer than ten bit times apart.
- R10: `par_err_o`, `stop_err_o` and `gap_o` are 0 in every cycle where `valid_o` is 0.
- R11: A disturbance on `rx_i` lasting no more than one oversampling tick (`CLKS_PER_TICK` clocks) inside a bit does not change the received value of that bit.
- R12: A line held at 1 produces no strobe. No strobe occurs after the line has been continuously high for eleven bit times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| data_o | output | 8 | Received octet, LSB is the first data bit on the line |
| valid_o | output | 1 | One-cycle strobe per received character |
| par_err_o | output | 1 | Even-parity check failed for this character |
| stop_err_o | output | 1 | Stop position sampled as 0 |
| gap_o | output | 1 | One or more idle bit times preceded this character |

## Verification
The assertions check three properties on every cycle:
- the strobe is one cycle wide and consecutive strobes are spaced at least ten bit times apart;
- the error and gap flags never appear without the strobe;
- a line held high cannot produce a character.

The directed scenarios cover what depends on the bit content and the timing of the line:
- LSB-first assembly of the octet;
- detection of a corrupted parity bit and of a low stop bit;
- rejection of a short start pulse;
- immunity to a one-tick spike inside a data bit;
- the gap flag for back-to-back characters, for a one-bit idle gap, and for the first character after reset.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int CLKS_PER_TICK = 27
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rx_line_sampler.sv
module rx_line_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tick_i,
  output logic rx_s_o,
  output logic vote_o
);
  import rx_pkg::*;

  logic [1:0] sync_q;
  logic [1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      hist_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      if (tick_i) hist_q <= {hist_q[0], sync_q[1]};
    end
  end

  assign rx_s_o = sync_q[1];
  // two previous tick samples plus the current one
  assign vote_o = vote3(hist_q[1], hist_q[0], sync_q[1]);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm #(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_s_i,
  input  logic              vote_i,
  output logic              start_ok_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              stop_err_o
);
  import rx_pkg::*;

  localparam int OW = $clog2(OVERSAMPLE);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OW-1:0] MID  = OW'(OVERSAMPLE / 2 + 1);
  localparam logic [OW-1:0] LAST = OW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [OW-1:0]     os_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  logic              at_mid;
  logic              at_last;

  assign at_mid  = tick_i && (os_q == MID);
  assign at_last = tick_i && (os_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      os_q       <= '0;
      bit_q      <= '0;
      shreg_q    <= '0;
      par_q      <= 1'b0;
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      data_o     <= '0;
      par_err_o  <= 1'b0;
      stop_err_o <= 1'b0;
    end else begin
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      par_err_o  <= 1'b0;
      stop_err_o <= 1'b0;
      if (tick_i && state_q != ST_IDLE) os_q <= os_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (tick_i && !rx_s_i) begin
            state_q <= ST_START;
            os_q    <= OW'(1);
          end
        end
        ST_START: begin
          if (at_mid) begin
            if (vote_i) state_q <= ST_IDLE;   // glitch
            else        start_ok_o <= 1'b1;
          end
          if (at_last) begin
            state_q <= ST_DATA;
            bit_q   <= '0;
          end
        end
        ST_DATA: begin
          if (at_mid) shreg_q <= {vote_i, shreg_q[DATA_W-1:1]};
          if (at_last) begin
            if (bit_q == LAST_BIT) state_q <= ST_PARITY;
            else                   bit_q   <= bit_q + 1'b1;
          end
        end
        ST_PARITY: begin
          if (at_mid)  par_q   <= vote_i;
          if (at_last) state_q <= ST_STOP;
        end
        ST_STOP: begin
          if (at_mid) begin
            done_o     <= 1'b1;
            data_o     <= shreg_q;
            par_err_o  <= ^{shreg_q, par_q};
            stop_err_o <= ~vote_i;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_gap_meter.sv
module rx_gap_meter #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_ok_i,
  input  logic done_i,
  output logic gap_o
);
  // back-to-back: ~16 ticks from stop centre to next start centre; one idle bit: ~32
  localparam int THRESH = OVERSAMPLE + OVERSAMPLE / 2;
  localparam int GW = $clog2(THRESH + 1);
  localparam logic [GW-1:0] SAT = GW'(THRESH);

  logic [GW-1:0] cnt_q;
  logic          have_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      have_prev_q <= 1'b0;
      gap_o       <= 1'b0;
    end else begin
      if (done_i) begin
        cnt_q       <= '0;
        have_prev_q <= 1'b1;
      end else if (tick_i && cnt_q != SAT) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (start_ok_i) gap_o <= have_prev_q && (cnt_q >= SAT);
    end
  end
endmodule

// File: rtl/parity_char_rx.sv
module parity_char_rx #(
  parameter int CLKS_PER_TICK = 27,
  parameter int OVERSAMPLE    = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              stop_err_o,
  output logic              gap_o
);
  logic tick;
  logic rx_s;
  logic vote;
  logic start_ok;
  logic done;
  logic gap_q;

  rx_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  rx_line_sampler u_samp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .tick_i(tick),
    .rx_s_o(rx_s),
    .vote_o(vote)
  );

  rx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .rx_s_i    (rx_s),
    .vote_i    (vote),
    .start_ok_o(start_ok),
    .done_o    (done),
    .data_o    (data_o),
    .par_err_o (par_err_o),
    .stop_err_o(stop_err_o)
  );

  rx_gap_meter #(.OVERSAMPLE(OVERSAMPLE)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .start_ok_i(start_ok),
    .done_i    (done),
    .gap_o     (gap_q)
  );

  assign valid_o = done;
  assign gap_o   = done & gap_q;
endmodule

// File: rtl/parity_char_rx_chk.sv
module parity_char_rx_chk #(
  parameter int CLKS_PER_TICK = 27,
  parameter int OVERSAMPLE    = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_i,
  input logic valid_o,
  input logic par_err_o,
  input logic stop_err_o,
  input logic gap_o
);
  localparam int BIT_CLKS = CLKS_PER_TICK * OVERSAMPLE;
  localparam int MIN_SP   = 10 * BIT_CLKS;
  localparam int MAX_HI   = 11 * BIT_CLKS;
  localparam int SW = $clog2(MIN_SP + 1);
  localparam int HW = $clog2(MAX_HI + 1);
  localparam logic [SW-1:0] SP_SAT = SW'(MIN_SP);
  localparam logic [HW-1:0] HI_SAT = HW'(MAX_HI);

  logic [SW-1:0] since_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= SP_SAT;
      hi_q    <= '0;
    end else begin
      if (valid_o)              since_q <= '0;
      else if (since_q != SP_SAT) since_q <= since_q + 1'b1;
      if (!rx_i)                hi_q <= '0;
      else if (hi_q != HI_SAT)  hi_q <= hi_q + 1'b1;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9
  AST_VALID_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> since_q >= SW'(MIN_SP - 1)); // R9
  AST_FLAGS_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(par_err_o || stop_err_o || gap_o)); // R10
  AST_IDLE_NO_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_q == HI_SAT) |-> !valid_o); // R12
endmodule

bind parity_char_rx parity_char_rx_chk #(
  .CLKS_PER_TICK(CLKS_PER_TICK),
  .OVERSAMPLE   (OVERSAMPLE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_i      (rx_i),
  .valid_o   (valid_o),
  .par_err_o (par_err_o),
  .stop_err_o(stop_err_o),
  .gap_o     (gap_o)
);

// File: tb/parity_char_rx_tb.sv
module parity_char_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_CLKS  = 4;
  localparam int OS         = 16;
  localparam int BIT        = TICK_CLKS * OS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [7:0] data;
  logic       valid, perr, serr, gap;

  int n_checks = 0;
  int n_fail   = 0;
  int n_rx     = 0;
  int vwidth   = 0;
  int vwidth_max = 0;
  logic [7:0] r_data [16];
  logic       r_perr [16];
  logic       r_serr [16];
  logic       r_gap  [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_char_rx #(.CLKS_PER_TICK(TICK_CLKS), .OVERSAMPLE(OS), .DATA_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .data_o(data), .valid_o(valid), .par_err_o(perr), .stop_err_o(serr), .gap_o(gap)
  );

  always @(negedge clk) begin
    if (valid) begin
      r_data[n_rx % 16] = data;
      r_perr[n_rx % 16] = perr;
      r_serr[n_rx % 16] = serr;
      r_gap[n_rx % 16]  = gap;
      n_rx++;
      vwidth++;
      if (vwidth > vwidth_max) vwidth_max = vwidth;
    end else begin
      vwidth = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic drive_spiked(input logic b);
    rx = b;
    repeat (BIT/2 - 2) @(negedge clk);
    rx = ~b;
    repeat (TICK_CLKS) @(negedge clk);
    rx = b;
    repeat (BIT - BIT/2 + 2 - TICK_CLKS) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  task automatic send_char(input logic [7:0] d, input bit bad_par, input bit stop_v,
                           input int spike_idx);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) begin
      if (i == spike_idx) drive_spiked(d[i]);
      else                drive_bit(d[i]);
    end
    drive_bit(^d ^ bad_par);
    drive_bit(stop_v);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 valid in reset", int'(valid), 0);
    check("R1 flags in reset", int'({perr, serr, gap}), 0);
    rst_n = 1'b1;
    idle_bits(2);
    check("R1 valid after reset", int'(valid), 0);
    check("R1 flags after reset", int'({perr, serr, gap}), 0);
  endtask

  task automatic t_first_char;
    int base = n_rx;
    send_char(8'hA5, 0, 1, -1);
    idle_bits(3);
    check("R2 count", n_rx - base, 1);
    check("R2 data A5", int'(r_data[base % 16]), 'hA5);
    check("R3 no parity error", int'(r_perr[base % 16]), 0);
    check("R4 no stop error", int'(r_serr[base % 16]), 0);
    check("R8 first char gap", int'(r_gap[base % 16]), 0);
  endtask

  task automatic t_contiguous;
    int base = n_rx;
    idle_bits(2);
    send_char(8'h3C, 0, 1, -1);
    send_char(8'hC1, 0, 1, -1);
    idle_bits(3);
    check("R7 count", n_rx - base, 2);
    check("R2 data 3C", int'(r_data[base % 16]), 'h3C);
    check("R2 data C1", int'(r_data[(base + 1) % 16]), 'hC1);
    check("R5 gap after idle", int'(r_gap[base % 16]), 1);
    check("R7 back-to-back gap", int'(r_gap[(base + 1) % 16]), 0);
  endtask

  task automatic t_gap_one;
    int base = n_rx;
    send_char(8'h5A, 0, 1, -1);
    idle_bits(1);
    send_char(8'h81, 0, 1, -1);
    idle_bits(3);
    check("R5 count", n_rx - base, 2);
    check("R5 one-bit gap", int'(r_gap[(base + 1) % 16]), 1);
    check("R2 data 81", int'(r_data[(base + 1) % 16]), 'h81);
  endtask

  task automatic t_parity;
    int base = n_rx;
    send_char(8'h7E, 1, 1, -1);
    send_char(8'h7F, 0, 1, -1);
    idle_bits(3);
    check("R3 count", n_rx - base, 2);
    check("R3 bad parity flagged", int'(r_perr[base % 16]), 1);
    check("R3 data kept", int'(r_data[base % 16]), 'h7E);
    check("R3 good parity clean", int'(r_perr[(base + 1) % 16]), 0);
  endtask

  task automatic t_stop;
    int base = n_rx;
    send_char(8'h44, 0, 0, -1);
    idle_bits(4);
    check("R4 single char", n_rx - base, 1);
    check("R4 stop error", int'(r_serr[base % 16]), 1);
    check("R4 data kept", int'(r_data[base % 16]), 'h44);
  endtask

  task automatic t_glitch;
    int base = n_rx;
    rx = 1'b0;
    repeat (3 * TICK_CLKS) @(negedge clk);
    idle_bits(14);
    check("R6 R12 glitch no char", n_rx - base, 0);
    send_char(8'h99, 0, 1, -1);
    idle_bits(3);
    check("R6 recovery count", n_rx - base, 1);
    check("R6 recovery data", int'(r_data[base % 16]), 'h99);
  endtask

  task automatic t_spike;
    int base = n_rx;
    send_char(8'h00, 0, 1, 3);
    idle_bits(2);
    send_char(8'hFF, 0, 1, 5);
    idle_bits(3);
    check("R11 count", n_rx - base, 2);
    check("R11 low bit spike", int'(r_data[base % 16]), 'h00);
    check("R11 high bit spike", int'(r_data[(base + 1) % 16]), 'hFF);
    check("R11 parity clean", int'(r_perr[base % 16] | r_perr[(base + 1) % 16]), 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_char();
    t_contiguous();
    t_gap_one();
    t_parity();
    t_stop();
    t_glitch();
    t_spike();
    check("R9 strobe width", vwidth_max, 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule